// File: doc/BRIEF.md
# Serial FIFO Watermark and Transfer-Count Controller

This block keeps track of how many words sit in the transmit and receive FIFOs of a serial channel and decides when to ask for service. The bus side pushes words into the transmit FIFO and pops them from the receive FIFO. The shifter side does the reverse. The block counts occupancy on both sides and compares each count against a programmed watermark. It raises a level request that a DMA engine or an interrupt controller can use. It also flags the cases where a word is lost and the cases where a word is missing.

The block also counts the words the shifter has finished. When that count reaches a programmed transfer length, it raises a one-cycle end-of-count event and starts over. Both watermarks and the transfer length are programmed as values in the block. A watermark is written as the wanted level minus one. The two watermarks and the transfer length are written through separate strobes, so writing one never disturbs the others.

Top module: `spi_fifo_ctl`

## Requirements
- R1: While reset is held and on the first cycle after it, both occupancies read 0 and every request, status and event output is 0. Both watermark fields and the transfer length reset to 0.
- R2: With the transmit FIFO enabled, a push adds one to `tx_occ` and a pop subtracts one, visible the cycle after the strobe. A push while `tx_occ` equals FIFO_DEPTH (16 by default) is dropped. Whether a push or pop is accepted is judged on the occupancy at the start of that cycle. The receive FIFO counts the same way with `rx_push`/`rx_pop`.
- R3: `tx_req` is 1 exactly when the transmit FIFO is enabled and `tx_occ <= tx_ae_m1 + 1`, using the stored watermark.
- R4: `rx_req` is 1 exactly when the receive FIFO is enabled and `rx_occ >= rx_af_m1 + 1`. A level above FIFO_DEPTH never requests.
- R5: A receive push while `rx_occ` equals FIFO_DEPTH drops the word and pulses `rx_ovf` for one cycle, the cycle after the push. A pop in the same cycle still removes a word, leaving FIFO_DEPTH-1.
- R6: A transmit pop while `tx_occ` is 0 pulses `tx_udf` for one cycle, the cycle after the pop, and removes nothing. A push in the same cycle still lands, leaving 1. A receive pop on an empty receive FIFO raises no flag.
- R7: While a FIFO's enable is 0, its occupancy is forced to 0 from the next cycle. Its push and pop strobes are ignored, and its request, status and error outputs stay 0.
- R8: Each `word_done` pulse counts one word while at least one FIFO is enabled. On the word that brings the count to the programmed length, `eowc` is 1 for exactly the following cycle and counting restarts from zero.
- R9: A programmed transfer length of 0 never raises `eowc`.
- R10: A `lvl_wr` write stores both watermarks and leaves the transfer length and its progress unchanged. A `wc_wr` write stores the length, restarts progress from zero and leaves both watermarks unchanged.
- R11: `tx_empty` is 1 when the transmit FIFO is enabled and `tx_occ` is 0. `rx_full` is 1 when the receive FIFO is enabled and `rx_occ` equals FIFO_DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lvl_wr | input | 1 | Store both watermark fields |
| tx_ae_m1 | input | 8 | Transmit almost-empty level minus one |
| rx_af_m1 | input | 8 | Receive almost-full level minus one |
| wc_wr | input | 1 | Store the transfer length and restart counting |
| wc_val | input | 16 | Transfer length in words (0 disables the event) |
| tx_on | input | 1 | Transmit FIFO enable |
| rx_on | input | 1 | Receive FIFO enable |
| tx_push | input | 1 | Bus writes a word into the transmit FIFO |
| tx_pop | input | 1 | Shifter takes a word from the transmit FIFO |
| rx_push | input | 1 | Shifter writes a word into the receive FIFO |
| rx_pop | input | 1 | Bus reads a word from the receive FIFO |
| word_done | input | 1 | Shifter finished one word |
| tx_occ | output | 5 | Transmit occupancy |
| rx_occ | output | 5 | Receive occupancy |
| tx_req | output | 1 | Transmit service request (level) |
| rx_req | output | 1 | Receive service request (level) |
| tx_empty | output | 1 | Transmit FIFO empty |
| rx_full | output | 1 | Receive FIFO full |
| tx_udf | output | 1 | Transmit underflow pulse |
| rx_ovf | output | 1 | Receive overflow pulse |
| eowc | output | 1 | End-of-transfer-count pulse |

## Verification
The bench sweeps the whole occupancy range of both FIFOs, from empty to full and one word past full and back, for several watermarks. These include level 1, a level equal to the depth and levels beyond it. An off-by-one in the minus-one encoding would show up as a request that starts one word early or late. The bench pushes and pops in the same cycle at the full and empty edges. A design that judged acceptance on the updated count would either lose the overflow or underflow pulse or end one word away from the expected count. Transfer lengths of 0, 1 and several words are run with back-to-back and spaced `word_done` pulses, with writes in between. A counter that failed to reload, fired at length zero, or lost its progress on a watermark write would show its pulse at the wrong word.

// File: rtl/spi_fq_pkg.sv
`timescale 1ns/1ps
package spi_fq_pkg;
    // Which side of the channel a FIFO occupancy tracker serves
    typedef enum logic {
        FIFO_TX = 1'b0,
        FIFO_RX = 1'b1
    } fifo_dir_e;
endpackage

// File: rtl/fifo_occ.sv
`timescale 1ns/1ps
module fifo_occ #(
    parameter spi_fq_pkg::fifo_dir_e DIR = spi_fq_pkg::FIFO_TX,
    parameter int DEPTH = 16,
    parameter int LVL_W = 8,
    localparam int OCC_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             push,
    input  logic             pop,
    input  logic [LVL_W-1:0] lvl_m1,
    output logic [OCC_W-1:0] occ,
    output logic             req,
    output logic             at_edge,
    output logic             err
);
    localparam int CMP_W = (OCC_W > LVL_W + 1) ? OCC_W : LVL_W + 1;

    typedef struct packed {
        logic [OCC_W-1:0] occ;
        logic             err;
    } st_t;

    st_t st_d, st_q;
    logic full, empty, do_push, do_pop, bad_op;
    logic [CMP_W-1:0] occ_x, lvl_x;

    always_comb begin
        full    = (st_q.occ == OCC_W'(DEPTH));
        empty   = (st_q.occ == '0);
        do_push = en && push && !full;
        do_pop  = en && pop && !empty;
        st_d.occ = en ? (st_q.occ + OCC_W'(do_push) - OCC_W'(do_pop)) : '0;
        st_d.err = en && bad_op;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign occ_x = CMP_W'(st_q.occ);
    assign lvl_x = CMP_W'(lvl_m1) + CMP_W'(1);

    generate
        if (DIR == spi_fq_pkg::FIFO_TX) begin : g_tx
            assign bad_op  = pop && empty;
            assign req     = en && (occ_x <= lvl_x);
            assign at_edge = en && empty;
        end else begin : g_rx
            assign bad_op  = push && full;
            assign req     = en && (occ_x >= lvl_x);
            assign at_edge = en && full;
        end
    endgenerate

    assign occ = st_q.occ;
    assign err = st_q.err;

    // R2: occupancy never leaves the physical range
    a_r2_occ_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.occ <= OCC_W'(DEPTH));
    // R7: a disabled FIFO is empty on the next cycle
    a_r7_off_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (st_q.occ == '0));
    // R5 and R6: an error pulse only follows an operation at the full or empty edge
    a_r5_r6_err_edge: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.err |-> ($past(st_q.occ) == ((DIR == spi_fq_pkg::FIFO_TX) ? OCC_W'(0) : OCC_W'(DEPTH))));
    // R2: occupancy moves by at most one per cycle while enabled
    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> ((st_q.occ == $past(st_q.occ)) || (st_q.occ == $past(st_q.occ) + OCC_W'(1))
                || (st_q.occ == $past(st_q.occ) - OCC_W'(1)) || !$past(en)));
endmodule

// File: rtl/word_cnt.sv
`timescale 1ns/1ps
module word_cnt #(
    parameter int WC_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr,
    input  logic [WC_W-1:0] val,
    input  logic            word_done,
    input  logic            active,
    output logic            eowc
);
    typedef struct packed {
        logic [WC_W-1:0] prog;
        logic [WC_W-1:0] done;
        logic            eowc;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.eowc = 1'b0;
        if (wr) begin
            st_d.prog = val;
            st_d.done = '0;
        end else if (word_done && active && (st_q.prog != '0)) begin
            if (st_q.done + WC_W'(1) == st_q.prog) begin
                st_d.done = '0;
                st_d.eowc = 1'b1;
            end else begin
                st_d.done = st_q.done + WC_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign eowc = st_q.eowc;

    // R9: no end-of-count event while the length is zero
    a_r9_zero_silent: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.eowc |-> (st_q.prog != '0));
    // R8: progress stays below a non-zero length
    a_r8_progress: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.prog != '0) |-> (st_q.done < st_q.prog));
    // R8: the event is caused by a counted word
    a_r8_cause: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.eowc |-> $past(word_done && active));
    // R10: the length only changes on its own write strobe
    a_r10_prog_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(st_q.prog));
endmodule

// File: rtl/spi_fifo_ctl.sv
`timescale 1ns/1ps
module spi_fifo_ctl #(
    parameter int FIFO_DEPTH = 16,
    parameter int LVL_W = 8,
    parameter int WC_W = 16,
    localparam int OCC_W = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lvl_wr,
    input  logic [LVL_W-1:0] tx_ae_m1,
    input  logic [LVL_W-1:0] rx_af_m1,
    input  logic             wc_wr,
    input  logic [WC_W-1:0]  wc_val,
    input  logic             tx_on,
    input  logic             rx_on,
    input  logic             tx_push,
    input  logic             tx_pop,
    input  logic             rx_push,
    input  logic             rx_pop,
    input  logic             word_done,
    output logic [OCC_W-1:0] tx_occ,
    output logic [OCC_W-1:0] rx_occ,
    output logic             tx_req,
    output logic             rx_req,
    output logic             tx_empty,
    output logic             rx_full,
    output logic             tx_udf,
    output logic             rx_ovf,
    output logic             eowc
);
    typedef struct packed {
        logic [LVL_W-1:0] tx_m1;
        logic [LVL_W-1:0] rx_m1;
    } lvl_t;

    lvl_t lvl_d, lvl_q;

    always_comb begin
        lvl_d = lvl_q;
        if (lvl_wr) begin
            lvl_d.tx_m1 = tx_ae_m1;
            lvl_d.rx_m1 = rx_af_m1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= '0;
        else        lvl_q <= lvl_d;
    end

    fifo_occ #(.DIR(spi_fq_pkg::FIFO_TX), .DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) i_tx_occ (
        .clk(clk), .rst_n(rst_n), .en(tx_on), .push(tx_push), .pop(tx_pop),
        .lvl_m1(lvl_q.tx_m1), .occ(tx_occ), .req(tx_req), .at_edge(tx_empty), .err(tx_udf)
    );

    fifo_occ #(.DIR(spi_fq_pkg::FIFO_RX), .DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) i_rx_occ (
        .clk(clk), .rst_n(rst_n), .en(rx_on), .push(rx_push), .pop(rx_pop),
        .lvl_m1(lvl_q.rx_m1), .occ(rx_occ), .req(rx_req), .at_edge(rx_full), .err(rx_ovf)
    );

    word_cnt #(.WC_W(WC_W)) i_word_cnt (
        .clk(clk), .rst_n(rst_n), .wr(wc_wr), .val(wc_val),
        .word_done(word_done), .active(tx_on || rx_on), .eowc(eowc)
    );

    // R10: watermarks only change on their own write strobe
    a_r10_lvl_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !lvl_wr |=> $stable(lvl_q));
    // R7: a disabled side raises no request or error
    a_r7_tx_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_on && !$past(tx_on)) |-> (!tx_req && !tx_udf && !tx_empty));
    a_r7_rx_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_on && !$past(rx_on)) |-> (!rx_req && !rx_ovf && !rx_full));
    // R11: full and empty flags never both on one side at depth > 0
    a_r11_tx_empty: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> (tx_occ == '0));
    a_r11_rx_full: assert property (@(posedge clk) disable iff (!rst_n)
        rx_full |-> (rx_occ == OCC_W'(FIFO_DEPTH)));
endmodule

// File: tb/test_spi_fifo_ctl.sv
`timescale 1ns/1ps
module test_spi_fifo_ctl;
    localparam int DEPTH = 16;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n, lvl_wr, wc_wr, tx_on, rx_on, tx_push, tx_pop, rx_push, rx_pop, word_done;
    logic [7:0] tx_ae_m1, rx_af_m1;
    logic [15:0] wc_val;
    logic [4:0] tx_occ, rx_occ;
    logic tx_req, rx_req, tx_empty, rx_full, tx_udf, rx_ovf, eowc;

    int n_cmp = 0;
    int n_bad = 0;

    spi_fifo_ctl i_spi_fifo_ctl (
        .clk(clk), .rst_n(rst_n), .lvl_wr(lvl_wr), .tx_ae_m1(tx_ae_m1), .rx_af_m1(rx_af_m1),
        .wc_wr(wc_wr), .wc_val(wc_val), .tx_on(tx_on), .rx_on(rx_on),
        .tx_push(tx_push), .tx_pop(tx_pop), .rx_push(rx_push), .rx_pop(rx_pop),
        .word_done(word_done), .tx_occ(tx_occ), .rx_occ(rx_occ), .tx_req(tx_req),
        .rx_req(rx_req), .tx_empty(tx_empty), .rx_full(rx_full), .tx_udf(tx_udf),
        .rx_ovf(rx_ovf), .eowc(eowc)
    );

    task automatic chk(input string tag, input int got, input int exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic set_lvl(input int t, input int r);
        lvl_wr = 1'b1; tx_ae_m1 = 8'(t); rx_af_m1 = 8'(r);
        tick();
        lvl_wr = 1'b0;
    endtask

    task automatic set_wc(input int v);
        wc_wr = 1'b1; wc_val = 16'(v);
        tick();
        wc_wr = 1'b0;
    endtask

    task automatic word();
        word_done = 1'b1;
        tick();
        word_done = 1'b0;
    endtask

    task automatic pushes(input bit rx, input int n);
        for (int i = 0; i < n; i++) begin
            if (rx) rx_push = 1'b1; else tx_push = 1'b1;
            tick();
            rx_push = 1'b0; tx_push = 1'b0;
        end
    endtask

    task automatic pops(input bit rx, input int n);
        for (int i = 0; i < n; i++) begin
            if (rx) rx_pop = 1'b1; else tx_pop = 1'b1;
            tick();
            rx_pop = 1'b0; tx_pop = 1'b0;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got 0 expected 1 (run did not finish)");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int tx_lv[4];
        int rx_lv[5];
        tx_lv = '{0, 4, 15, 40};
        rx_lv = '{0, 7, 15, 16, 200};
        rst_n = 1'b0; lvl_wr = 0; wc_wr = 0; tx_on = 0; rx_on = 0;
        tx_push = 0; tx_pop = 0; rx_push = 0; rx_pop = 0; word_done = 0;
        tx_ae_m1 = 0; rx_af_m1 = 0; wc_val = 0;
        repeat (3) tick();
        // R1 during and after reset
        chk("R1 tx_occ in reset", tx_occ, 0);
        chk("R1 outputs in reset", {tx_req, rx_req, tx_empty, rx_full, tx_udf, rx_ovf, eowc}, 0);
        rst_n = 1'b1;
        tick();
        chk("R1 rx_occ after reset", rx_occ, 0);
        chk("R1 outputs after reset", {tx_req, rx_req, tx_empty, rx_full, tx_udf, rx_ovf, eowc}, 0);

        tx_on = 1'b1; rx_on = 1'b1;
        tick();
        chk("R11 tx_empty once enabled", tx_empty, 1);
        chk("R3 reset watermark gives level 1 at occ 0", tx_req, 1);

        // R2 R3 R6 R11: transmit sweep
        foreach (tx_lv[j]) begin
            set_lvl(tx_lv[j], 0);
            chk("R3 tx_req at occ 0", tx_req, 1);
            for (int k = 1; k <= DEPTH + 1; k++) begin
                int e;
                pushes(1'b0, 1);
                e = (k > DEPTH) ? DEPTH : k;
                chk("R2 tx_occ on fill", tx_occ, e);
                chk("R3 tx_req on fill", tx_req, (e <= tx_lv[j] + 1) ? 1 : 0);
                chk("R11 tx_empty on fill", tx_empty, 0);
            end
            for (int k = 1; k <= DEPTH + 1; k++) begin
                int e;
                pops(1'b0, 1);
                e = (k > DEPTH) ? 0 : DEPTH - k;
                chk("R2 tx_occ on drain", tx_occ, e);
                chk("R3 tx_req on drain", tx_req, (e <= tx_lv[j] + 1) ? 1 : 0);
                chk("R6 tx_udf on drain", tx_udf, (k > DEPTH) ? 1 : 0);
            end
            tick();
            chk("R6 tx_udf lasts one cycle", tx_udf, 0);
            chk("R11 tx_empty after drain", tx_empty, 1);
        end

        // R2 R4 R5 R11: receive sweep
        foreach (rx_lv[j]) begin
            set_lvl(0, rx_lv[j]);
            chk("R4 rx_req at occ 0", rx_req, 0);
            for (int k = 1; k <= DEPTH + 1; k++) begin
                int e;
                pushes(1'b1, 1);
                e = (k > DEPTH) ? DEPTH : k;
                chk("R2 rx_occ on fill", rx_occ, e);
                chk("R4 rx_req on fill", rx_req, (e >= rx_lv[j] + 1) ? 1 : 0);
                chk("R5 rx_ovf on fill", rx_ovf, (k > DEPTH) ? 1 : 0);
                chk("R11 rx_full on fill", rx_full, (e == DEPTH) ? 1 : 0);
            end
            tick();
            chk("R5 rx_ovf lasts one cycle", rx_ovf, 0);
            for (int k = 1; k <= DEPTH + 1; k++) begin
                int e;
                pops(1'b1, 1);
                e = (k > DEPTH) ? 0 : DEPTH - k;
                chk("R2 rx_occ on drain", rx_occ, e);
                chk("R4 rx_req on drain", rx_req, (e >= rx_lv[j] + 1) ? 1 : 0);
                chk("R6 rx pop on empty raises nothing", rx_ovf, 0);
            end
        end

        // R5: push and pop together on a full receive FIFO
        pushes(1'b1, DEPTH);
        rx_push = 1'b1; rx_pop = 1'b1;
        tick();
        rx_push = 1'b0; rx_pop = 1'b0;
        chk("R5 rx_occ after push+pop at full", rx_occ, DEPTH - 1);
        chk("R5 rx_ovf after push+pop at full", rx_ovf, 1);
        pops(1'b1, DEPTH - 1);
        chk("R2 rx drained", rx_occ, 0);

        // R6: push and pop together on an empty transmit FIFO
        tx_push = 1'b1; tx_pop = 1'b1;
        tick();
        chk("R6 tx_occ after push+pop at empty", tx_occ, 1);
        chk("R6 tx_udf after push+pop at empty", tx_udf, 1);
        tick();
        tx_push = 1'b0; tx_pop = 1'b0;
        chk("R2 tx_occ push+pop mid-range", tx_occ, 1);
        chk("R6 no tx_udf mid-range", tx_udf, 0);
        pops(1'b0, 1);
        chk("R2 tx back to empty", tx_occ, 0);

        // R7: disable behaviour
        set_lvl(7, 1);
        pushes(1'b0, 5);
        pushes(1'b1, 3);
        chk("R7 tx filled before disable", tx_occ, 5);
        tx_on = 1'b0; rx_on = 1'b0;
        tick();
        chk("R7 tx_occ cleared", tx_occ, 0);
        chk("R7 rx_occ cleared", rx_occ, 0);
        chk("R7 outputs quiet", {tx_req, rx_req, tx_empty, rx_full}, 0);
        pushes(1'b0, 3);
        pushes(1'b1, DEPTH + 4);
        chk("R7 tx push ignored", tx_occ, 0);
        chk("R7 rx push ignored", rx_occ, 0);
        chk("R7 no rx_ovf while off", rx_ovf, 0);
        pops(1'b0, 1);
        chk("R7 no tx_udf while off", tx_udf, 0);
        tx_on = 1'b1; rx_on = 1'b1;
        tick();
        chk("R7 tx_occ zero on re-enable", tx_occ, 0);
        chk("R7 rx_occ zero on re-enable", rx_occ, 0);

        // R8: several transfer lengths
        for (int n = 1; n <= 5; n += 2) begin
            set_wc(n);
            for (int i = 1; i <= 2 * n + 1; i++) begin
                word();
                chk("R8 eowc after word", eowc, (i % n == 0) ? 1 : 0);
                tick();
                chk("R8 eowc one cycle", eowc, 0);
            end
        end
        // R8: back-to-back words with length 1
        set_wc(1);
        word_done = 1'b1;
        for (int i = 0; i < 3; i++) begin
            tick();
            chk("R8 eowc back-to-back length 1", eowc, 1);
        end
        word_done = 1'b0;
        tick();
        chk("R8 eowc drops", eowc, 0);
        // R8: words not counted with both FIFOs off
        set_wc(2);
        tx_on = 1'b0; rx_on = 1'b0;
        word(); word(); word();
        chk("R8 no counting while off", eowc, 0);
        tx_on = 1'b1; rx_on = 1'b1;
        word();
        chk("R8 first counted word", eowc, 0);
        word();
        chk("R8 second counted word", eowc, 1);

        // R9: zero length
        set_wc(0);
        for (int i = 0; i < 10; i++) begin
            word();
            chk("R9 zero length silent", eowc, 0);
        end

        // R10: watermark write keeps progress, count write keeps watermarks
        set_lvl(3, 5);
        set_wc(4);
        word(); word();
        set_lvl(9, 9);
        word();
        chk("R10 progress kept, word 3", eowc, 0);
        word();
        chk("R10 progress kept, word 4", eowc, 1);
        set_wc(3);
        word(); word();
        set_wc(3);
        word(); word();
        chk("R10 count write restarts progress", eowc, 0);
        word();
        chk("R10 restarted length reached", eowc, 1);
        pushes(1'b0, 10);
        chk("R10 tx watermark kept at occ 10", tx_req, 1);
        pushes(1'b0, 1);
        chk("R10 tx watermark kept at occ 11", tx_req, 0);
        pushes(1'b1, 9);
        chk("R10 rx watermark kept at occ 9", rx_req, 0);
        pushes(1'b1, 1);
        chk("R10 rx watermark kept at occ 10", rx_req, 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule